// File: doc/BRIEF.md
# Turn-Signal Blinker Controller

This block drives a pair of direction indicators from two push buttons. A short press on one button gives exactly three complete on/off flashes on that side's lamp, after which the controller goes back to waiting. If the button is still held when a flash ends, one more flash follows, and this repeats until the button is let go. Each side has its own speed switch, which halves that side's on and off times. A buzzer output carries a square tone, but only while a lamp is lit.

Both buttons pass through a two-stage synchronizer and a debouncer before the sequencer sees them. The sequencer remembers which side it serves for the whole sequence, so the other button cannot take over part way through. With the default parameters (100 MHz clock) the tone is 1 kHz, a normal flash lasts 2^26 cycles and the debounce window is 10 ms. The bench uses small parameters so that every timing can be counted cycle by cycle.

Top module: `turn_blinker`

## Requirements
- R1: While `rst_n` is low and after it is released with no button pressed, `led_left`, `led_right` and `tone` are all 0.
- R2: A press of one button that is released before its third flash ends gives exactly three flashes on that side's lamp. With the speed switch off, each flash is lit for 2^HALF_LOG2 cycles and dark for 2^HALF_LOG2 cycles. After the third flash the lamp stays dark.
- R3: When a flash ends, a button that is still held (after debouncing) starts one more flash right away. The first flash that ends after the debounced release is the last one.
- R4: When both debounced buttons rise in the same cycle while the controller is idle, no sequence starts and both lamps stay dark.
- R5: Once a sequence has started, the other button has no effect until the controller is idle again. The two lamps are never lit in the same cycle.
- R6: When a side's speed switch is 1, that side's lit and dark times are each 2^(HALF_LOG2-1) cycles. The other side's switch has no effect on the timing.
- R7: The speed switch is sampled once, as each flash starts. A change during a flash first affects the next flash.
- R8: `tone` is 0 in every cycle in which no lamp is lit. While a lamp is lit, `tone` follows a free-running square wave that toggles every CLK_HZ/(2*TONE_HZ) cycles.
- R9: A button pulse shorter than DEBOUNCE_CYCLES cycles starts no sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_left | input | 1 | Left push button, raw, 1 = pressed |
| btn_right | input | 1 | Right push button, raw, 1 = pressed |
| fast_left | input | 1 | Left speed switch, 1 = double rate |
| fast_right | input | 1 | Right speed switch, 1 = double rate |
| led_left | output | 1 | Left lamp, 1 = lit |
| led_right | output | 1 | Right lamp, 1 = lit |
| tone | output | 1 | Buzzer square wave, gated by the lit lamp |

## Verification
The bench measures every lit run and every dark run of each sequence and counts the flashes. A counter that is off by one shows up as a wrong width, and a flawed decision at the end of a flash shows up as a burst of two or four flashes, or as a sequence that never stops. The held-button cases release the button at a chosen point inside a flash, so that a design that tests the button too early or too late gives a flash count that differs by one. The bench also toggles a speed switch in the middle of a flash, which exposes a design that changes rate part way through or reads the wrong side's switch. Simultaneous presses, a press on the other side during a sequence and a short glitch each have to leave the lamps dark or untouched, and a tone that leaks outside the lit windows or has the wrong half-period is caught in every cycle.

// File: rtl/blink_pkg.sv
// Package: shared types for the turn-signal blinker.
// Assumes nothing beyond IEEE 1800-2017.
package blink_pkg;

    // Sequencer phase: waiting, lamp lit, lamp dark.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ON   = 2'd1,
        PH_OFF  = 2'd2
    } phase_t;

endpackage

// File: rtl/blink_debounce.sv
// Module: blink_debounce
// Brings one asynchronous button level into the clock domain through two
// flops, then accepts a new level only after it has stayed constant for
// STABLE_CYCLES consecutive cycles.
// Assumes: STABLE_CYCLES >= 1, synchronous active-low reset.
module blink_debounce #(
    parameter int STABLE_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);

    logic          meta;
    logic          synced;
    logic [CW-1:0] cnt;

    // Two-flop synchronizer for the raw level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta   <= 1'b0;
            synced <= 1'b0;
        end else begin
            meta   <= raw;
            synced <= meta;
        end
    end

    // Stability counter: commit the new level once it has held long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            clean <= 1'b0;
        end else if (synced == clean) begin
            cnt <= '0;
        end else if (cnt == CW'(STABLE_CYCLES - 1)) begin
            clean <= synced;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_DEB_ACCEPTS_SYNCED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clean) |-> ($past(synced) == clean)); // R9

endmodule

// File: rtl/blink_tone.sv
// Module: blink_tone
// Free-running square wave that toggles every HALF_PERIOD cycles; the
// output is forced low whenever enable is 0.
// Assumes: HALF_PERIOD >= 2, synchronous active-low reset.
module blink_tone #(
    parameter int HALF_PERIOD = 50_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tone
);
    localparam int DW = $clog2(HALF_PERIOD + 1);

    logic [DW-1:0] div_cnt;
    logic          square;

    // Divider: flip the square wave at the end of each half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            square  <= 1'b0;
        end else if (div_cnt == DW'(HALF_PERIOD - 1)) begin
            div_cnt <= '0;
            square  <= ~square;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign tone = square & enable;

    AST_TONE_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt <= DW'(HALF_PERIOD - 1)); // R8

endmodule

// File: rtl/turn_blinker.sv
// Module: turn_blinker (top)
// Left/right indicator sequencer. A press of a single button starts a
// burst of BURST_FLASHES flashes on that side; a button still held when a
// flash ends extends the burst by one flash. Each side's speed switch
// halves its lit and dark times, sampled once per flash. The tone is gated
// by the lit lamp.
// Assumes: HALF_LOG2 >= 2, BURST_FLASHES >= 1, synchronous active-low reset.
module turn_blinker
    import blink_pkg::*;
#(
    parameter int CLK_HZ          = 100_000_000,
    parameter int TONE_HZ         = 1000,
    parameter int HALF_LOG2       = 25,
    parameter int DEBOUNCE_CYCLES = CLK_HZ / 100,
    parameter int BURST_FLASHES   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_left,
    input  logic btn_right,
    input  logic fast_left,
    input  logic fast_right,
    output logic led_left,
    output logic led_right,
    output logic tone
);
    localparam int TONE_HALF = CLK_HZ / (2 * TONE_HZ);
    localparam int BW        = $clog2(BURST_FLASHES + 1);
    localparam logic [HALF_LOG2-1:0] LOAD_SLOW = '1;
    localparam logic [HALF_LOG2-1:0] LOAD_FAST = LOAD_SLOW >> 1;

    logic [1:0] btn_raw;
    logic [1:0] btn_deb;
    logic [1:0] sw_meta;
    logic [1:0] sw_sync;

    assign btn_raw = {btn_right, btn_left};

    // One conditioner per side: index 0 = left, 1 = right.
    for (genvar gi = 0; gi < 2; gi++) begin : g_side
        blink_debounce #(.STABLE_CYCLES(DEBOUNCE_CYCLES)) u_deb (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (btn_raw[gi]),
            .clean (btn_deb[gi])
        );
    end

    // Two-flop synchronizer for the speed switches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_meta <= '0;
            sw_sync <= '0;
        end else begin
            sw_meta <= {fast_right, fast_left};
            sw_sync <= sw_meta;
        end
    end

    phase_t                phase;
    logic                  side_q;     // 0 = left, 1 = right
    logic                  fast_q;     // rate of the flash in progress
    logic [HALF_LOG2-1:0]  cnt;
    logic [BW-1:0]         remaining;

    logic start_fast;
    logic next_fast;
    logic held;
    logic lit;

    function automatic logic [HALF_LOG2-1:0] load_for(input logic f);
        return f ? LOAD_FAST : LOAD_SLOW;
    endfunction

    // Switch and button views used when starting or extending a sequence.
    always_comb begin
        start_fast = btn_deb[1] ? sw_sync[1] : sw_sync[0];
        next_fast  = side_q ? sw_sync[1] : sw_sync[0];
        held       = side_q ? btn_deb[1] : btn_deb[0];
    end

    // Sequencer: idle wait, lit phase, dark phase with end-of-flash decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            side_q    <= 1'b0;
            fast_q    <= 1'b0;
            cnt       <= '0;
            remaining <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (btn_deb[0] ^ btn_deb[1]) begin
                        side_q    <= btn_deb[1];
                        fast_q    <= start_fast;
                        cnt       <= load_for(start_fast);
                        remaining <= BW'(BURST_FLASHES);
                        phase     <= PH_ON;
                    end
                end
                PH_ON: begin
                    if (cnt == '0) begin
                        cnt   <= load_for(fast_q);
                        phase <= PH_OFF;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_OFF: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (remaining > BW'(1) || held) begin
                        if (remaining > BW'(1)) begin
                            remaining <= remaining - 1'b1;
                        end
                        fast_q <= next_fast;
                        cnt    <= load_for(next_fast);
                        phase  <= PH_ON;
                    end else begin
                        remaining <= '0;
                        phase     <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign lit       = (phase == PH_ON);
    assign led_left  = lit & ~side_q;
    assign led_right = lit & side_q;

    blink_tone #(.HALF_PERIOD(TONE_HALF)) u_tone (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (lit),
        .tone   (tone)
    );

    AST_BOTH_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && btn_deb[0] && btn_deb[1]) |=> (phase == PH_IDLE)); // R4

    AST_SIDE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(side_q)); // R5

    AST_RATE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_OFF || (phase == PH_ON && $past(phase) == PH_ON)) |-> $stable(fast_q)); // R7

    AST_BURST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |-> (remaining != '0 && remaining <= BW'(BURST_FLASHES))); // R2

endmodule

// File: tb/turn_blinker_tb.sv
`timescale 1ns/1ps
module turn_blinker_tb;
    localparam int CLK_HZ  = 4000;
    localparam int TONE_HZ = 500;
    localparam int HL2     = 4;
    localparam int DEB     = 4;
    localparam int BURST   = 3;
    localparam int H_SLOW  = 1 << HL2;
    localparam int H_FAST  = 1 << (HL2 - 1);
    localparam int T_HALF  = CLK_HZ / (2 * TONE_HZ);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_left = 1'b0, btn_right = 1'b0, fast_left = 1'b0, fast_right = 1'b0;
    logic led_left, led_right, tone;

    int errors = 0;
    int checks = 0;
    int tone_runs = 0;

    always #2.5 clk = ~clk;

    turn_blinker #(
        .CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ), .HALF_LOG2(HL2),
        .DEBOUNCE_CYCLES(DEB), .BURST_FLASHES(BURST)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .btn_left(btn_left), .btn_right(btn_right),
        .fast_left(fast_left), .fast_right(fast_right),
        .led_left(led_left), .led_right(led_right), .tone(tone)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle monitor: lamps exclusive (R5), tone dark and half-period (R8).
    logic prev_tone = 1'b0, prev_lit = 1'b0;
    int   run_len = 0;
    bit   run_ok = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (led_left && led_right) check(1'b0, "R5 both lamps lit", 1, 0);
            if (tone && !(led_left || led_right)) check(1'b0, "R8 tone while dark", 1, 0);
            if (tone != prev_tone) begin
                if (run_ok && (led_left || led_right) && prev_lit) begin
                    tone_runs++;
                    check(run_len == T_HALF, "R8 tone half-period", run_len, T_HALF);
                end
                run_len = 1;
                run_ok  = (led_left || led_right) && prev_lit;
            end else begin
                run_len++;
            end
            if (!(led_left || led_right)) run_ok = 1'b0;
            prev_tone = tone;
            prev_lit  = led_left || led_right;
        end
    end

    task automatic set_btn(input bit side, input bit v);
        if (side) btn_right = v; else btn_left = v;
    endtask

    task automatic set_fast(input bit side, input bit v);
        if (side) fast_right = v; else fast_left = v;
    endtask

    // Check that both lamps stay dark for n cycles.
    task automatic expect_dark(input int n, input string req);
        int lit_seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (led_left || led_right) lit_seen++;
        end
        check(lit_seen == 0, req, lit_seen, 0);
    endtask

    // Press one side, then measure every lit and dark run until quiet.
    task automatic run_seq(input bit side, input int rel_at, input int tog_at,
                           input int oth_on, input int oth_off, input int exp_n,
                           input int h_first, input int h_rest, input string req);
        int  flashes = 0, on_len = 0, off_len = 0, waited = 0, h;
        bit  prev = 1'b0, s, o;
        @(negedge clk);
        set_btn(side, 1'b1);
        do begin
            @(negedge clk);
            waited++;
            s = side ? led_right : led_left;
        end while (!s && waited < 40);
        check(s, {req, " sequence start"}, int'(s), 1);
        for (int c = 0; c < 4000; c++) begin
            s = side ? led_right : led_left;
            o = side ? led_left : led_right;
            if (o) check(1'b0, {req, " other lamp lit (R5)"}, 1, 0);
            if (s && !prev) begin
                if (flashes > 0) begin
                    h = (flashes - 1 == 0) ? h_first : h_rest;
                    check(off_len == h, {req, " dark width"}, off_len, h);
                end
                flashes++;
                on_len = 1;
            end else if (s) begin
                on_len++;
            end else if (prev) begin
                h = (flashes - 1 == 0) ? h_first : h_rest;
                check(on_len == h, {req, " lit width"}, on_len, h);
                off_len = 1;
            end else begin
                off_len++;
            end
            prev = s;
            if (c == rel_at)  set_btn(side, 1'b0);
            if (c == tog_at)  set_fast(side, ~(side ? fast_right : fast_left));
            if (c == oth_on)  set_btn(~side, 1'b1);
            if (c == oth_off) set_btn(~side, 1'b0);
            if (!s && off_len >= 2 * H_SLOW + 8) break;
            @(negedge clk);
        end
        check(flashes == exp_n, {req, " flash count"}, flashes, exp_n);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!led_left && !led_right && !tone, "R1 in reset", {led_left, led_right, tone}, 0);
        rst_n = 1'b1;
        expect_dark(30, "R1 after reset");
        check(!tone, "R1 tone after reset", tone, 0);

        // R2: short presses, normal rate, both sides
        run_seq(1'b0, 0, -1, -1, -1, BURST, H_SLOW, H_SLOW, "R2 left short");
        run_seq(1'b1, 0, -1, -1, -1, BURST, H_SLOW, H_SLOW, "R2 right short");

        // R3: held through three flashes, released inside flash 3 -> 4 flashes
        run_seq(1'b0, 3 * 2 * H_SLOW + H_SLOW / 2 + 2, -1, -1, -1, 4, H_SLOW, H_SLOW, "R3 left held");

        // R3 and R6: right held at fast rate, released inside flash 5 -> 6 flashes
        fast_right = 1'b1;
        run_seq(1'b1, 5 * 2 * H_FAST + H_FAST / 2 + 2, -1, -1, -1, 6, H_FAST, H_FAST, "R6 right fast held");

        // R6: right switch on has no effect on the left side
        run_seq(1'b0, 0, -1, -1, -1, BURST, H_SLOW, H_SLOW, "R6 left with right switch");
        fast_right = 1'b0;

        // R7: left switch turned on during flash 0, later flashes fast
        run_seq(1'b0, 0, 5, -1, -1, BURST, H_SLOW, H_FAST, "R7 mid-flash switch");
        fast_left = 1'b0;
        expect_dark(10, "R7 idle after burst");

        // R4: both buttons pressed in the same cycle
        @(negedge clk);
        btn_left = 1'b1;
        btn_right = 1'b1;
        expect_dark(80, "R4 both pressed");
        btn_left = 1'b0;
        btn_right = 1'b0;
        expect_dark(20, "R4 after release");

        // R5: right pressed during a left burst is ignored
        run_seq(1'b0, 0, -1, 3, 40, BURST, H_SLOW, H_SLOW, "R5 other button");
        expect_dark(20, "R5 no late right start");

        // R9: glitch shorter than the debounce window
        @(negedge clk);
        btn_left = 1'b1;
        @(negedge clk);
        @(negedge clk);
        btn_left = 1'b0;
        expect_dark(60, "R9 glitch");

        // R8: tone half-period was measured inside lit windows
        check(tone_runs > 0, "R8 tone runs observed", tone_runs, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule